// File: doc/BRIEF.md
# Pause Holdoff Timer with Received Pause Frame Handling

This block turns received flow-control pause requests into a holdoff signal for a MAC transmitter. An upstream parser hands it one strobe per decoded pause frame, with the frame's 16-bit quantum, a flag for a bad checksum or other receive fault, and a flag saying that per-priority flow control is in force. Frames that pass the filter load a countdown timer. While that timer is non-zero the block tells the transmitter to hold off. The transmitter finishes any frame it is sending and then reports that it has stopped.

The timer only counts down while the transmitter reports that it has stopped. In normal operation one quantum lasts 512 bit times. On an 8-bit-per-clock datapath that is 64 clocks, produced by a freezing prescaler. A test input shortens each quantum to one clock. When the timer counts down to zero, or an accepted frame carries a zero quantum, the block sets a sticky status flag. Software clears the flag by writing one to a clear input. The flag drives the interrupt line only when the enable input is high. A saturating counter tallies the accepted frames.

Top module: `pause_holdoff_unit`

## Requirements
- R1: After a synchronous reset, `hold_tx`, `irq_status`, `irq_out` and `rx_pause_count` are all 0.
- R2: A frame strobe with `frm_err` high changes neither the timer, the prescaler, the counter nor the status flag. This holds even while a countdown is in progress.
- R3: A frame strobe while `pfc_on` is high is discarded in the same way as an errored frame.
- R4: An accepted frame has `frm_valid`=1, `frm_err`=0 and `pfc_on`=0. On the next edge it increments `rx_pause_count` and loads the timer with `frm_quanta`, replacing any count in progress. It also restarts the prescaler from zero, and `hold_tx` goes high when the quantum is non-zero.
- R5: With `fast_step`=0, `hold_tx` falls after exactly Q*64 rising edges on which `tx_halted` was high, counted from the edge that loaded quantum Q. Edges with `tx_halted` low neither count nor reset the prescaler.
- R6: With `fast_step`=1, the timer decrements on every edge with `tx_halted` high, so `hold_tx` falls after exactly Q such edges.
- R7: `irq_status` is set on the same edge on which a decrement brings the timer to zero. It stays 0 during the countdown.
- R8: An accepted frame with quantum 0 drives `hold_tx` low on the next edge, sets `irq_status` and increments the counter.
- R9: On each edge, `irq_out` is registered as the next value of `irq_status` ANDed with `irq_en`. It stays 0 whenever `irq_en` was low.
- R10: A high `irq_clr` clears `irq_status` on the next edge. A set event on the same edge takes priority over the clear.
- R11: `rx_pause_count` saturates at 2^CNT_W-1 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe for a decoded pause frame |
| frm_quanta | input | QUANTA_W | Pause quantum carried by the frame |
| frm_err | input | 1 | Frame had a checksum or other receive error |
| pfc_on | input | 1 | Priority-based flow control is negotiated |
| tx_halted | input | 1 | Transmitter has stopped sending |
| fast_step | input | 1 | Test mode: one quantum per clock |
| irq_en | input | 1 | Interrupt enable for the pause flag |
| irq_clr | input | 1 | Write-one-to-clear for the pause flag |
| hold_tx | output | 1 | Pause active, transmitter must hold off |
| rx_pause_count | output | CNT_W | Saturating count of accepted pause frames |
| irq_status | output | 1 | Sticky pause-expired or zero-quantum flag |
| irq_out | output | 1 | Enabled interrupt |

## Verification
A prescaler that is off by one, resets at the wrong time or keeps running while the transmitter runs changes how long `hold_tx` stays high. That shows up as a count of halted edges that differs from Q*64 by the size of the error. A timer that is wrongly reloaded, or disturbed by a rejected frame, shows the same kind of length error one countdown later. The bench measures these lengths with steady halting, with alternating halting, after mid-count reloads and after rejected frames. A bad flag or counter path shows at the next edge after the event, in `irq_status`, `irq_out` or `rx_pause_count`.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int QUANTA_W = 16;

  typedef struct packed {
    logic                accept;
    logic                zero_q;
    logic [QUANTA_W-1:0] quanta;
  } pause_cmd_t;
endpackage

// File: rtl/pause_frame_filter.sv
module pause_frame_filter
  import pause_pkg::*;
(
  input  logic                frm_valid,
  input  logic [QUANTA_W-1:0] frm_quanta,
  input  logic                frm_err,
  input  logic                pfc_on,
  output pause_cmd_t          cmd
);
  // Errored frames and plain pause frames under PFC are both dropped here.
  always_comb begin
    cmd.accept = frm_valid && !frm_err && !pfc_on;
    cmd.quanta = frm_quanta;
    cmd.zero_q = (frm_quanta == '0);
  end
endmodule

// File: rtl/pause_countdown.sv
module pause_countdown #(
  parameter int QUANTA_W   = 16,
  parameter int PRESCALE_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [QUANTA_W-1:0] load_val,
  input  logic                tx_halted,
  input  logic                fast_step,
  output logic                hold_tx,
  output logic                zero_hit
);
  logic [QUANTA_W-1:0] cnt;
  logic running, wrap, step;

  assign running = tx_halted && (cnt != '0);

  generate
    if (PRESCALE_W > 0) begin : g_pre
      logic [PRESCALE_W-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst || load)   pre <= '0;
        else if (running)  pre <= fast_step ? '0 : pre + 1'b1;
      end
      assign wrap = (pre == {PRESCALE_W{1'b1}});
    end else begin : g_nopre
      assign wrap = 1'b1;
    end
  endgenerate

  assign step     = running && (fast_step || wrap);
  assign zero_hit = step && !load && (cnt == QUANTA_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      hold_tx <= 1'b0;
    end else if (load) begin
      cnt     <= load_val;
      hold_tx <= (load_val != '0);
    end else if (step) begin
      cnt     <= cnt - 1'b1;
      hold_tx <= (cnt != QUANTA_W'(1));
    end else begin
      hold_tx <= (cnt != '0);
    end
  end

  // R5: no countdown progress while the transmitter is still sending
  a_r5_frozen_when_sending: assert property (@(posedge clk) disable iff (rst)
    (!tx_halted && !load) |=> $stable(cnt));

  // R6: timer never moves by more than one step per clock
  a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pause_stat_counter.sv
module pause_stat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                          count <= '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end

  // R11: counter holds at its ceiling
  a_r11_saturate: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX) |=> (count == CNT_MAX));
endmodule

// File: rtl/pause_irq_ctrl.sv
module pause_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr,
  input  logic en,
  output logic status,
  output logic irq
);
  logic status_nxt;

  always_comb begin
    if (set_evt)  status_nxt = 1'b1;
    else if (clr) status_nxt = 1'b0;
    else          status_nxt = status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 1'b0;
      irq    <= 1'b0;
    end else begin
      status <= status_nxt;
      irq    <= status_nxt && en;
    end
  end

  // R10: a clear without a competing set empties the flag
  a_r10_w1c: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_evt) |=> !status);

  // R10: set event wins
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> status);

  // R9: masked flag never reaches the line
  a_r9_masked: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);
endmodule

// File: rtl/pause_holdoff_unit.sv
module pause_holdoff_unit
  import pause_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PRESCALE_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frm_valid,
  input  logic [QUANTA_W-1:0] frm_quanta,
  input  logic                frm_err,
  input  logic                pfc_on,
  input  logic                tx_halted,
  input  logic                fast_step,
  input  logic                irq_en,
  input  logic                irq_clr,
  output logic                hold_tx,
  output logic [CNT_W-1:0]    rx_pause_count,
  output logic                irq_status,
  output logic                irq_out
);
  pause_cmd_t cmd;
  logic       zero_hit;
  logic       irq_set;

  pause_frame_filter u_filter (
    .frm_valid (frm_valid),
    .frm_quanta(frm_quanta),
    .frm_err   (frm_err),
    .pfc_on    (pfc_on),
    .cmd       (cmd)
  );

  pause_countdown #(
    .QUANTA_W  (QUANTA_W),
    .PRESCALE_W(PRESCALE_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (cmd.accept),
    .load_val (cmd.quanta),
    .tx_halted(tx_halted),
    .fast_step(fast_step),
    .hold_tx  (hold_tx),
    .zero_hit (zero_hit)
  );

  pause_stat_counter #(.CNT_W(CNT_W)) u_stats (
    .clk  (clk),
    .rst  (rst),
    .inc  (cmd.accept),
    .count(rx_pause_count)
  );

  assign irq_set = zero_hit || (cmd.accept && cmd.zero_q);

  pause_irq_ctrl u_irq (
    .clk    (clk),
    .rst    (rst),
    .set_evt(irq_set),
    .clr    (irq_clr),
    .en     (irq_en),
    .status (irq_status),
    .irq    (irq_out)
  );

  // R2: errored frames leave the statistics untouched
  a_r2_err_dropped: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_err) |=> $stable(rx_pause_count));

  // R3: frames under PFC leave the statistics untouched
  a_r3_pfc_dropped: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && pfc_on) |=> $stable(rx_pause_count));

  // R7: end of holdoff always comes with the flag
  a_r7_expiry_flag: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_tx) |-> irq_status);

  // R8: zero-quantum accepted frame releases the transmitter and flags
  a_r8_zero_quanta: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !frm_err && !pfc_on && frm_quanta == '0) |=> (!hold_tx && irq_status));
endmodule

// File: tb/pause_holdoff_unit_test.sv
`timescale 1ns/1ps
module pause_holdoff_unit_test;
  localparam int CW  = 4;
  localparam int CMX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_valid = 0, frm_err = 0, pfc_on = 0;
  logic [15:0] frm_quanta = '0;
  logic tx_halted = 0, fast_step = 0, irq_en = 0, irq_clr = 0;
  logic hold_tx, irq_status, irq_out;
  logic [CW-1:0] rx_pause_count;

  int checks = 0, fails = 0, exp_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pause_holdoff_unit #(.CNT_W(CW), .PRESCALE_W(6)) uut (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_quanta(frm_quanta),
    .frm_err(frm_err), .pfc_on(pfc_on), .tx_halted(tx_halted),
    .fast_step(fast_step), .irq_en(irq_en), .irq_clr(irq_clr),
    .hold_tx(hold_tx), .rx_pause_count(rx_pause_count),
    .irq_status(irq_status), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(input int q, input bit err, input bit pfc, input bit clr);
    @(negedge clk);
    frm_valid = 1; frm_quanta = 16'(q); frm_err = err; pfc_on = pfc; irq_clr = clr;
    @(negedge clk);
    frm_valid = 0; frm_err = 0; pfc_on = 0; irq_clr = 0;
    if (!err && !pfc && exp_cnt < CMX) exp_cnt++;
  endtask

  task automatic clear_flag();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic halt_for(input int n);
    tx_halted = 1;
    for (int i = 0; i < n; i++) @(negedge clk);
    tx_halted = 0;
  endtask

  // pattern 0: steady halt, 1: alternate halted and sending
  task automatic run_hold(input int pat, output int n, output bit early_flag);
    int guard = 0;
    n = 0; early_flag = 0;
    while (hold_tx && guard < 20000) begin
      if (irq_status) early_flag = 1;
      tx_halted = (pat == 0) ? 1'b1 : (guard % 2 == 0);
      @(negedge clk);
      if (tx_halted) n++;
      guard++;
    end
    tx_halted = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit early;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(hold_tx == 0 && irq_status == 0 && irq_out == 0, "R1", hold_tx + irq_status + irq_out, 0);
    chk(rx_pause_count == 0, "R1", rx_pause_count, 0);
    irq_en = 1;

    // R2 errored frame
    frame(5, 1, 0, 0);
    chk(rx_pause_count == 0 && hold_tx == 0, "R2", rx_pause_count + hold_tx, 0);
    // R3 frame under PFC
    frame(5, 0, 1, 0);
    chk(rx_pause_count == 0 && hold_tx == 0 && irq_status == 0, "R3", rx_pause_count + hold_tx, 0);

    // R4 / R5 / R7 / R9 / R10 normal-mode sweep
    for (int q = 1; q <= 4; q++) begin
      frame(q, 0, 0, 0);
      chk(rx_pause_count == CW'(exp_cnt), "R4", rx_pause_count, exp_cnt);
      chk(hold_tx == 1, "R4", hold_tx, 1);
      run_hold(0, n, early);
      chk(n == q * 64, "R5", n, q * 64);
      chk(!early, "R7", early, 0);
      chk(irq_status == 1, "R7", irq_status, 1);
      chk(irq_out == 1, "R9", irq_out, 1);
      clear_flag();
      chk(irq_status == 0 && irq_out == 0, "R10", irq_status, 0);
    end

    // R5 intermittent halting
    frame(2, 0, 0, 0);
    run_hold(1, n, early);
    chk(n == 128, "R5", n, 128);
    clear_flag();

    // R6 fast sweep
    fast_step = 1;
    for (int q = 1; q <= 8; q++) begin
      frame(q, 0, 0, 0);
      run_hold(0, n, early);
      chk(n == q, "R6", n, q);
      chk(irq_status == 1 && !early, "R6", irq_status, 1);
      clear_flag();
    end
    fast_step = 0;
    chk(rx_pause_count == CW'(exp_cnt), "R4", rx_pause_count, exp_cnt);

    // R4 reload mid-countdown restarts the prescaler
    frame(2, 0, 0, 0);
    halt_for(100);
    frame(1, 0, 0, 0);
    run_hold(0, n, early);
    chk(n == 64, "R4", n, 64);
    clear_flag();

    // R2 rejected frame mid-countdown
    frame(1, 0, 0, 0);
    halt_for(30);
    frame(9, 1, 0, 0);
    chk(rx_pause_count == CW'(exp_cnt), "R2", rx_pause_count, exp_cnt);
    run_hold(0, n, early);
    chk(n == 34, "R2", n, 34);
    clear_flag();

    // R8 zero quantum cancels a running pause
    frame(3, 0, 0, 0);
    chk(hold_tx == 1, "R8", hold_tx, 1);
    frame(0, 0, 0, 0);
    chk(hold_tx == 0 && irq_status == 1, "R8", hold_tx, 0);
    chk(rx_pause_count == CW'(exp_cnt), "R8", rx_pause_count, exp_cnt);

    // R9 mask
    irq_en = 0;
    @(negedge clk);
    chk(irq_out == 0 && irq_status == 1, "R9", irq_out, 0);
    irq_en = 1;
    @(negedge clk);
    chk(irq_out == 1, "R9", irq_out, 1);

    // R10 set wins over simultaneous clear
    clear_flag();
    frame(0, 0, 0, 1);
    chk(irq_status == 1, "R10", irq_status, 1);
    clear_flag();

    // R11 saturation
    for (int i = 0; i < 20; i++) frame(0, 0, 0, 0);
    chk(rx_pause_count == CW'(CMX), "R11", rx_pause_count, CMX);
    chk(exp_cnt == CMX, "R11", exp_cnt, CMX);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule